// File: doc/BRIEF.md
# Multidrop UART receiver with mute

This block receives asynchronous serial frames on a shared line that carries traffic for many nodes. It oversamples the line with an external tick that runs at sixteen times the bit rate. A majority vote over three mid-bit samples decides each bit. Two control inputs pick one of four frame layouts: a length select and a parity enable. Reception raises a data-ready flag, and it can also raise a parity error, a framing error or an overrun. A stretch of quiet line raises an idle flag. An interrupt request combines these flags.

Software can place the receiver in a mute state so that it ignores traffic meant for other nodes. While muted, no status flag can be set and the interrupt request stays low. A wake-method input picks how the receiver leaves mute. With the input at 0, a full frame time of idle line unmutes it. With the input at 1, a received word whose address bit is 1 unmutes it, and that word is delivered as ordinary data. The mute bit is written through a strobe and a data bit. A write of a stale value that was read while muted puts the receiver back into mute, even if a wake has already happened.

Top module: `mpx_rx`

## Requirements
- R1: After reset, rdy, ovr, perr, ferr, idle, muted and irq are all 0, and rx_data is 0.
- R2: Bits arrive LSB first after a low start bit. The field after the start bit is 8 bits wide when len9=0 and 9 bits wide when len9=1, and a stop bit follows it. When par_en=1, the top bit of the field (bit 7 or bit 8) is a parity bit. rx_data holds the field with the parity position forced to 0.
- R3: A start bit is accepted only if at least two of samples 7, 8 and 9 are low, counting the first low sample as sample 0. A shorter low pulse produces no frame.
- R4: With par_en=1, the field (data plus parity) must have an even number of ones when par_odd=0 and an odd number when par_odd=1. A mismatch sets perr along with rdy.
- R5: A stop bit that is sampled low sets ferr along with rdy.
- R6: If rdy is still 1 when a frame completes, ovr is set and rx_data, perr and ferr keep their values. A one-cycle rd pulse clears rdy, ovr, perr, ferr and idle.
- R7: While the receiver hunts for a start bit and is not muted, a line held high for (field width + 2) x 16 ticks sets idle. This happens once per quiet stretch.
- R8: While muted is 1, a completed frame that does not wake the receiver sets none of rdy, ovr, perr, ferr or idle.
- R9: With wake_addr=0, an idle frame time clears muted and leaves idle at 0.
- R10: With wake_addr=1, a frame whose address bit is 1 clears muted and is delivered as a normal word. The address bit is field bit 7 (len9=0) or bit 8 (len9=1) when par_en=0. It is bit 6 or bit 7 when par_en=1, so the parity bit is not used.
- R11: A mute_wr pulse loads mute_wdata into muted, and this takes priority over any wake in the same cycle. Writing back a 1 that was read before an address wake mutes the receiver again, and the frames that follow without an address bit are ignored.
- R12: irq is 1 exactly when muted is 0 and at least one of rdy, ovr or idle is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle enable at 16x the bit rate |
| rxd | input | 1 | Serial line, idle high |
| len9 | input | 1 | 1 selects a 9-bit field, 0 an 8-bit field |
| par_en | input | 1 | Top bit of the field is parity |
| par_odd | input | 1 | 1 selects odd parity, 0 even |
| wake_addr | input | 1 | 1 wakes on an address bit, 0 wakes on an idle line |
| mute_wr | input | 1 | Write strobe for the mute bit |
| mute_wdata | input | 1 | Value written to the mute bit |
| rd | input | 1 | Read strobe that clears the status flags |
| rx_data | output | 9 | Last delivered word |
| rdy | output | 1 | Data ready |
| idle | output | 1 | Idle line seen |
| perr | output | 1 | Parity error |
| ferr | output | 1 | Framing error |
| ovr | output | 1 | Overrun |
| muted | output | 1 | Mute state |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default values: 16 samples per bit and a two-stage input synchronizer. It drives the tick every second clock, so one bit spans 32 clocks and an idle frame stays short enough to reach within a few hundred cycles. With these values, the bench can place a start-bit glitch below the vote window and a false start after a low stop bit. It can also reach both wake methods, the stale-write hazard, and overruns from random frames across all four layouts.

// File: rtl/mpx_rx.sv
module mpx_rx #(
  parameter int OSR  = 16,
  parameter int SYNC = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       rxd,
  input  logic       len9,
  input  logic       par_en,
  input  logic       par_odd,
  input  logic       wake_addr,
  input  logic       mute_wr,
  input  logic       mute_wdata,
  input  logic       rd,
  output logic [8:0] rx_data,
  output logic       rdy,
  output logic       idle,
  output logic       perr,
  output logic       ferr,
  output logic       ovr,
  output logic       muted,
  output logic       irq
);
  localparam int SCW = $clog2(OSR);
  localparam int ICW = $clog2(11 * OSR + 1);
  localparam int V0  = OSR / 2 - 1;
  localparam int V1  = OSR / 2;
  localparam int V2  = OSR / 2 + 1;

  typedef enum logic [1:0] {HUNT, START, DATA, STOP} st_t;

  st_t            st;
  logic [SYNC-1:0] sync;
  logic [SCW-1:0] sc;
  logic [3:0]     bitn;
  logic           v0, v1;
  logic [8:0]     sh;
  logic [ICW-1:0] icnt;

  wire            rxs  = sync[SYNC-1];
  wire            maj  = (v0 & v1) | (v0 & rxs) | (v1 & rxs);
  wire [3:0]      nb   = len9 ? 4'd9 : 4'd8;
  wire [ICW-1:0]  lim  = len9 ? ICW'(11 * OSR) : ICW'(10 * OSR);
  wire            at_v2 = tick && sc == SCW'(V2);
  wire            at_end = sc == SCW'(OSR - 1);

  wire            done    = at_v2 && st == STOP;
  wire            par_bad = par_en && ((^sh) != par_odd);
  wire            addr    = par_en ? sh[nb - 4'd2] : sh[nb - 4'd1];
  wire [8:0]      word    = par_en ? (sh & ~(9'd1 << (nb - 4'd1))) : sh;
  wire            wake_a  = done && muted && wake_addr && addr;
  wire            take    = done && (!muted || wake_a);
  wire            idle_ev = tick && st == HUNT && rxs && icnt == lim - ICW'(1);
  wire            wake_i  = idle_ev && muted && !wake_addr;

  assign irq = !muted && (rdy || ovr || idle);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync <= '1;
    else        sync <= {sync[SYNC-2:0], rxd};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= HUNT; sc <= '0; bitn <= '0; v0 <= 1'b1; v1 <= 1'b1; sh <= '0;
    end else if (tick) begin
      if (st == HUNT) begin
        if (!rxs) begin
          st <= START; sc <= SCW'(1); bitn <= '0; sh <= '0;
        end
      end else begin
        sc <= at_end ? '0 : sc + SCW'(1);
        if (sc == SCW'(V0)) v0 <= rxs;
        if (sc == SCW'(V1)) v1 <= rxs;
        if (sc == SCW'(V2)) begin
          if (st == START && maj) st <= HUNT;
          if (st == DATA) sh[bitn] <= maj;
          if (st == STOP) st <= HUNT;
        end
        if (at_end) begin
          if (st == START) st <= DATA;
          else if (st == DATA) begin
            if (bitn == nb - 4'd1) st <= STOP;
            else bitn <= bitn + 4'd1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) icnt <= '0;
    else if (st != HUNT) icnt <= '0;
    else if (tick) begin
      if (!rxs) icnt <= '0;
      else if (icnt < lim) icnt <= icnt + ICW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) muted <= 1'b0;
    else if (mute_wr) muted <= mute_wdata;
    else if (wake_a || wake_i) muted <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy <= 1'b0; ovr <= 1'b0; perr <= 1'b0; ferr <= 1'b0; idle <= 1'b0;
      rx_data <= '0;
    end else begin
      if (rd) begin
        rdy <= 1'b0; ovr <= 1'b0; perr <= 1'b0; ferr <= 1'b0; idle <= 1'b0;
      end
      if (take) begin
        if (rdy) ovr <= 1'b1;
        else begin
          rdy     <= 1'b1;
          rx_data <= word;
          perr    <= par_bad;
          ferr    <= !maj;
        end
      end
      if (idle_ev && !muted) idle <= 1'b1;
    end
  end
endmodule

// File: rtl/mpx_rx_chk.sv
module mpx_rx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rd,
  input logic       mute_wr,
  input logic       mute_wdata,
  input logic [8:0] rx_data,
  input logic       rdy,
  input logic       idle,
  input logic       perr,
  input logic       ferr,
  input logic       ovr,
  input logic       muted,
  input logic       irq
);
  assert_rdy_unmuted_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdy) |-> !muted);
  assert_perr_unmuted_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(perr) |-> !muted);
  assert_ferr_unmuted_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ferr) |-> !muted);
  assert_idle_not_on_wake_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(idle) |-> !$past(muted));
  assert_ovr_needs_rdy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr) |-> $past(rdy));
  assert_data_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy && $past(rdy)) |-> $stable(rx_data));
  assert_mute_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mute_wr) |-> muted == $past(mute_wdata));
  assert_irq_gated_R12: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !muted);
endmodule

bind mpx_rx mpx_rx_chk u_chk (.*);

// File: tb/tb_mpx_rx.sv
`timescale 1ns/1ps
module tb_mpx_rx;
  localparam int BITC = 32;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, rxd = 1'b1;
  logic len9 = 0, par_en = 0, par_odd = 0, wake_addr = 0;
  logic mute_wr = 0, mute_wdata = 0, rd = 0;
  logic [8:0] rx_data;
  logic rdy, idle, perr, ferr, ovr, muted, irq;

  int n_chk = 0, n_err = 0;
  bit finished = 0;

  logic m_rdy, m_ovr, m_perr, m_ferr, m_mute;
  logic [8:0] m_data;

  mpx_rx dut (.*);

  always #10 clk = ~clk;
  always @(negedge clk) if (rst_n) tick <= ~tick;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drive_bit(input logic v);
    rxd = v;
    wait_clk(BITC);
  endtask

  task automatic send(input logic [8:0] f, input int nb, input logic stopv, input int gap);
    drive_bit(1'b0);
    for (int i = 0; i < nb; i++) drive_bit(f[i]);
    drive_bit(stopv);
    rxd = 1'b1;
    wait_clk(gap * BITC + 2);
  endtask

  task automatic pulse_rd();
    rd = 1; wait_clk(1); rd = 0; wait_clk(1);
    m_rdy = 0; m_ovr = 0; m_perr = 0; m_ferr = 0;
  endtask

  task automatic write_mute(input logic v);
    mute_wdata = v; mute_wr = 1; wait_clk(1); mute_wr = 0; wait_clk(1);
    m_mute = v;
  endtask

  function automatic logic [8:0] exp_word(input logic [8:0] f, input int nb, input logic pe);
    logic [8:0] w = f;
    if (pe) w[nb-1] = 1'b0;
    return w;
  endfunction

  function automatic logic addr_of(input logic [8:0] f, input int nb, input logic pe);
    return pe ? f[nb-2] : f[nb-1];
  endfunction

  function automatic logic [8:0] with_par(input logic [8:0] d, input int nb, input logic odd, input logic bad);
    logic [8:0] f = '0;
    logic p = odd;
    for (int i = 0; i < nb - 1; i++) begin f[i] = d[i]; p = p ^ d[i]; end
    f[nb-1] = p ^ bad;
    return f;
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=running expected=done");
    summary();
  end

  initial begin
    logic saved;
    void'($urandom(32'h5eed_1234));
    wait_clk(4);
    rst_n = 1;
    wait_clk(2);
    chk("R1 reset flags", {rdy, ovr, perr, ferr, idle, muted, irq, rx_data}, '0);

    wait_clk(400);
    chk("R7 idle after quiet line", idle, 1);
    chk("R12 irq on idle", irq, 1);
    pulse_rd();
    chk("R6 rd clears idle", {idle, irq}, 0);

    send(9'h0A5, 8, 1, 0);
    chk("R2 8-bit word", {rdy, perr, ferr, rx_data}, {3'b100, 9'h0A5});
    pulse_rd();
    len9 = 1;
    send(9'h1C3, 9, 1, 0);
    chk("R2 9-bit word", {rdy, rx_data}, {1'b1, 9'h1C3});
    pulse_rd();

    len9 = 0; par_en = 1; par_odd = 0;
    send(with_par(9'h35, 8, 0, 0), 8, 1, 0);
    chk("R4 even parity good", {rdy, perr, rx_data}, {2'b10, 9'h035});
    pulse_rd();
    send(with_par(9'h35, 8, 0, 1), 8, 1, 0);
    chk("R4 even parity bad", {rdy, perr}, 2'b11);
    pulse_rd();
    par_odd = 1; len9 = 1;
    send(with_par(9'h0E1, 9, 1, 0), 9, 1, 0);
    chk("R4 odd parity good 9-bit", {rdy, perr, rx_data}, {2'b10, 9'h0E1});
    pulse_rd();
    par_en = 0; par_odd = 0; len9 = 0;

    send(9'h03C, 8, 0, 2);
    chk("R5 low stop bit", {rdy, ferr, rx_data}, {2'b11, 9'h03C});
    pulse_rd();

    send(9'h011, 8, 1, 0);
    send(9'h022, 8, 1, 0);
    chk("R6 overrun keeps first word", {rdy, ovr, rx_data}, {2'b11, 9'h011});
    pulse_rd();
    chk("R6 rd clears all", {rdy, ovr, perr, ferr}, 0);

    rxd = 0; wait_clk(10); rxd = 1; wait_clk(100);
    chk("R3 short low pulse ignored", rdy, 0);
    send(9'h05A, 8, 1, 0);
    chk("R3 frame after glitch", {rdy, rx_data}, {1'b1, 9'h05A});
    pulse_rd();

    wake_addr = 1; par_en = 1; par_odd = 0;
    write_mute(1);
    send(with_par(9'h05, 8, 0, 1), 8, 0, 2);
    chk("R8 muted suppresses flags", {rdy, perr, ferr, ovr, irq, muted}, 6'b000001);
    send(9'h080, 8, 1, 0);
    chk("R10 parity bit is not address", {rdy, muted}, 2'b01);
    send(with_par(9'h45, 8, 0, 0), 8, 1, 0);
    chk("R10 address wake with parity", {rdy, muted, rx_data}, {2'b10, 9'h045});
    pulse_rd();
    par_en = 0;

    wake_addr = 0;
    write_mute(1);
    send(9'h0F0, 8, 1, 0);
    chk("R8 muted frame dropped", {rdy, muted}, 2'b01);
    wait_clk(400);
    chk("R9 idle wake clears mute, no idle flag", {muted, idle}, 2'b00);
    wait_clk(400);
    chk("R9 no idle on same quiet stretch", idle, 0);
    send(9'h00F, 8, 1, 0);
    pulse_rd();
    wait_clk(400);
    chk("R7 idle after frame", {idle, irq}, 2'b11);
    pulse_rd();

    wake_addr = 1;
    write_mute(1);
    saved = muted;
    send(9'h081, 8, 1, 0);
    chk("R10 address wake", {rdy, muted, rx_data}, {2'b10, 9'h081});
    write_mute(saved);
    chk("R11 stale write re-mutes", muted, 1);
    pulse_rd();
    send(9'h005, 8, 1, 0);
    chk("R11 later frame ignored", {rdy, muted}, 2'b01);
    write_mute(0);
    chk("R11 write clears mute", muted, 0);

    len9 = 1; wait_clk(400); pulse_rd();
    m_rdy = 0; m_ovr = 0; m_perr = 0; m_ferr = 0; m_mute = muted; m_data = rx_data;
    for (int it = 0; it < 140; it++) begin
      int nb, gap;
      logic [8:0] f, d;
      logic stopv;
      len9 = $urandom % 2; par_en = $urandom % 2; par_odd = $urandom % 2;
      nb = len9 ? 9 : 8;
      if ($urandom % 4 != 0) pulse_rd();
      if (!m_mute && $urandom % 8 == 0) begin
        wake_addr = $urandom % 2; write_mute(1);
      end else if (m_mute && $urandom % 6 == 0) write_mute(0);
      d = 9'($urandom);
      if (par_en) f = with_par(d, nb, par_odd, ($urandom % 5) == 0);
      else f = d & ((9'd1 << nb) - 9'd1);
      stopv = ($urandom % 8) != 0;
      gap = stopv ? $urandom % 4 : 1 + $urandom % 3;
      send(f, nb, stopv, gap);
      if (!m_mute || (wake_addr && addr_of(f, nb, par_en))) begin
        m_mute = 0;
        if (m_rdy) m_ovr = 1;
        else begin
          m_rdy = 1; m_data = exp_word(f, nb, par_en);
          m_perr = par_en && ((^f) != par_odd);
          m_ferr = !stopv;
        end
      end
      chk("R2/R4/R5/R6/R8/R10/R12 random frame",
          {muted, rdy, ovr, perr, ferr, idle, irq, rx_data},
          {m_mute, m_rdy, m_ovr, m_perr, m_ferr, 1'b0,
           !m_mute && (m_rdy || m_ovr), m_data});
    end
    summary();
  end
endmodule